// File: doc/BRIEF.md
# Interrupt Shadow-Register and Entry Controller

This unit gives a small 32-bit processor its interrupt machinery without control and status registers. It watches each offered instruction for the custom0 major opcode and carries out five private operations on its own state. That state is four shadow words, an interrupt mask and a pending-request register. Thirty-two request lines are edge-latched into the pending register. When entry is enabled and some pending line is not masked, the unit takes the interrupt. It discards the offered instruction and redirects fetch to a fixed handler address. It saves the current program counter in shadow word 0 and the set of delivered requests in shadow word 1.

The handler reads the shadow words into general registers, uses words 2 and 3 as scratch space, adjusts the mask, and returns. The return instruction redirects to shadow word 0 and enables entry again. A wait instruction holds the pipeline until something is pending. All outputs are combinational from the registered state and the offered instruction. The fetch pipeline acts on a redirect, a register write-back or a stall in the same cycle it is offered.

Top module: `irq_unit`

## Requirements
- R1: An instruction is decoded only when `instr_valid` is 1 and `instr[6:0]` is 7'b0001011. It is legal when `instr[14:12]` is 3'b000, `instr[24:20]` is 5'b00000 and `instr[31:25]` is 0 (read shadow), 1 (write shadow), 2 (return), 3 (swap mask) or 4 (wait). Any other custom0 encoding raises `illegal` in that cycle and has no other effect. Non-custom0 instructions are ignored.
- R2: Read shadow drives `rd_we`=1, `rd_addr`=`instr[11:7]` and `rd_data` = shadow word `instr[16:15]`, all in the same cycle.
- R3: Write shadow stores `rs1_val` into shadow word `instr[8:7]` at the clock edge. It does not write back.
- R4: Swap mask writes back the old mask (zero-extended) to `instr[11:7]` and loads `rs1_val` as the new mask. A mask bit of 1 stops that pending line from causing entry.
- R5: A 0-to-1 transition on `irq_req[i]` sets pending bit i at the next edge, even when the same bit is being cleared. A line held high sets it only once.
- R6: Entry occurs when entry is enabled, the offered instruction is not a wait, and pending AND NOT mask is nonzero. In that cycle `redirect_valid`=1 and `redirect_pc`=HANDLER_ADDR, and the offered instruction is discarded. At the edge, shadow 0 takes `pc`, shadow 1 takes the delivered bits, and those bits leave the pending register.
- R7: From entry until a return, no further entry occurs. Requests arriving in that time stay pending and are taken after the return.
- R8: Return drives `redirect_valid`=1 with `redirect_pc` = shadow word 0 and enables entry from the next cycle.
- R9: Wait with an empty pending register drives `stall`=1 and writes nothing. With any pending bit set, including masked ones, it writes the whole pending register back to `instr[11:7]` and clears it.
- R10: After reset, pending is empty, every mask bit is 1 and entry is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr_valid | input | 1 | An instruction is offered this cycle |
| instr | input | 32 | Offered instruction word |
| rs1_val | input | XLEN | Value of the source register named by the instruction |
| pc | input | XLEN | Address of the offered instruction, saved on entry |
| irq_req | input | NIRQ | Interrupt request lines |
| rd_we | output | 1 | Write-back request |
| rd_addr | output | 5 | Write-back register index |
| rd_data | output | XLEN | Write-back value |
| redirect_valid | output | 1 | Fetch must jump this cycle |
| redirect_pc | output | XLEN | Jump target |
| stall | output | 1 | Hold the pipeline (wait with nothing pending) |
| illegal | output | 1 | Unknown custom0 encoding offered |

## Verification
The first stimulus is a directed series. It raises two lines together under a full mask, so a mask that is not applied shows up as an early entry. It then opens the mask, so a wrong delivered bitmask or a wrong saved return address shows up. It raises a third line inside the handler to separate correct entry blocking from re-entry. The wait instruction is then given a masked-only request, which must still complete. After that, several thousand cycles of seeded random instruction mixes and sparse request toggles are compared field by field against a behavioural model in the bench. This catches ordering faults between entry, wait and return when they meet in the same cycle.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;

  localparam logic [6:0] CUSTOM0_OPC = 7'b0001011;
  localparam logic [6:0] F7_GETQ     = 7'd0;
  localparam logic [6:0] F7_SETQ     = 7'd1;
  localparam logic [6:0] F7_RETIRQ   = 7'd2;
  localparam logic [6:0] F7_MASKIRQ  = 7'd3;
  localparam logic [6:0] F7_WAITIRQ  = 7'd4;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_GETQ,
    OP_SETQ,
    OP_RET,
    OP_MASK,
    OP_WAIT,
    OP_ILLEGAL
  } irq_op_e;

  typedef struct packed {
    irq_op_e    op;
    logic [4:0] rd;
    logic [1:0] q_src;
    logic [1:0] q_dst;
  } irq_dec_t;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/irq_decode.sv
module irq_decode
  import irq_unit_pkg::*;
(
  input  logic        valid,
  input  logic [31:0] instr,
  output irq_dec_t    dec
);
  logic unused_fields;
  assign unused_fields = ^instr[19:17];

  always_comb begin
    dec.rd    = instr[11:7];
    dec.q_src = instr[16:15];
    dec.q_dst = instr[8:7];
    dec.op    = OP_NONE;
    if (valid && instr[6:0] == CUSTOM0_OPC) begin
      if (instr[14:12] != 3'b000 || instr[24:20] != 5'b00000) begin
        dec.op = OP_ILLEGAL;
      end else begin
        unique case (instr[31:25])
          F7_GETQ:    dec.op = OP_GETQ;
          F7_SETQ:    dec.op = OP_SETQ;
          F7_RETIRQ:  dec.op = OP_RET;
          F7_MASKIRQ: dec.op = OP_MASK;
          F7_WAITIRQ: dec.op = OP_WAIT;
          default:    dec.op = OP_ILLEGAL;
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int NIRQ = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] req,
  input  logic [NIRQ-1:0] clr,
  output logic [NIRQ-1:0] pend
);
  logic [NIRQ-1:0] prev_q, pend_q, pend_d, edge_v;

  always_comb begin
    edge_v = req & ~prev_q;
    pend_d = (pend_q & ~clr) | edge_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= req;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

  AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_v != '0) |=> ((pend_q & $past(edge_v)) == $past(edge_v))); // R5
endmodule

// File: rtl/irq_qregs.sv
module irq_qregs #(
  parameter int XLEN = 32,
  parameter int NIRQ = 32,
  parameter int NQ   = 4
) (
  input  logic                  clk,
  input  logic                  wr_en,
  input  logic [$clog2(NQ)-1:0] wr_idx,
  input  logic [XLEN-1:0]       wr_data,
  input  logic                  entry,
  input  logic [XLEN-1:0]       entry_ret,
  input  logic [NIRQ-1:0]       entry_bits,
  input  logic [$clog2(NQ)-1:0] rd_idx,
  output logic [XLEN-1:0]       rd_data,
  output logic [XLEN-1:0]       q0
);
  logic [XLEN-1:0] q_q [NQ];
  logic [XLEN-1:0] q_d [NQ];
  logic [NQ-1:0]   q_en;

  for (genvar gi = 0; gi < NQ; gi++) begin : g_q
    if (gi == 0) begin : g_ret
      assign q_en[gi] = entry | (wr_en && wr_idx == gi);
      assign q_d[gi]  = entry ? entry_ret : wr_data;
    end else if (gi == 1) begin : g_bits
      assign q_en[gi] = entry | (wr_en && wr_idx == gi);
      assign q_d[gi]  = entry ? XLEN'(entry_bits) : wr_data;
    end else begin : g_scratch
      assign q_en[gi] = wr_en && wr_idx == gi;
      assign q_d[gi]  = wr_data;
    end

    always_ff @(posedge clk) begin
      if (q_en[gi]) q_q[gi] <= q_d[gi];
    end
  end

  assign rd_data = q_q[rd_idx];
  assign q0      = q_q[0];
endmodule

// File: rtl/irq_unit.sv
module irq_unit
  import irq_unit_pkg::*;
#(
  parameter int              XLEN         = 32,
  parameter int              NIRQ         = 32,
  parameter logic [XLEN-1:0] HANDLER_ADDR = 32'h0000_0010
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [XLEN-1:0] pc,
  input  logic [NIRQ-1:0] irq_req,
  output logic            rd_we,
  output logic [4:0]      rd_addr,
  output logic [XLEN-1:0] rd_data,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc,
  output logic            stall,
  output logic            illegal
);
  localparam int NQ = 4;

  logic            rst_ns;
  irq_dec_t        dec;
  irq_op_e         op_x;
  logic [NIRQ-1:0] pend, unmasked, clr;
  logic [NIRQ-1:0] mask_q, mask_d;
  logic            en_q, en_d;
  logic            take, wait_op, wait_done;
  logic [XLEN-1:0] q_rd, q0;

  irq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ns));

  irq_decode u_dec (.valid(instr_valid), .instr(instr), .dec(dec));

  irq_pending #(.NIRQ(NIRQ)) u_pend (
    .clk(clk), .rst_n(rst_ns), .req(irq_req), .clr(clr), .pend(pend)
  );

  irq_qregs #(.XLEN(XLEN), .NIRQ(NIRQ), .NQ(NQ)) u_q (
    .clk(clk),
    .wr_en(op_x == OP_SETQ), .wr_idx(dec.q_dst), .wr_data(rs1_val),
    .entry(take), .entry_ret(pc), .entry_bits(unmasked),
    .rd_idx(dec.q_src), .rd_data(q_rd), .q0(q0)
  );

  // entry decision and instruction qualification
  always_comb begin
    unmasked  = pend & ~mask_q;
    wait_op   = (dec.op == OP_WAIT);
    take      = en_q && (unmasked != '0) && !wait_op;
    op_x      = take ? OP_NONE : dec.op;
    wait_done = (op_x == OP_WAIT) && (pend != '0);
    if (take)           clr = unmasked;
    else if (wait_done) clr = pend;
    else                clr = '0;
  end

  // outputs
  always_comb begin
    rd_we          = 1'b0;
    rd_addr        = dec.rd;
    rd_data        = '0;
    redirect_valid = 1'b0;
    redirect_pc    = '0;
    stall          = (op_x == OP_WAIT) && (pend == '0);
    illegal        = (op_x == OP_ILLEGAL);
    if (take) begin
      redirect_valid = 1'b1;
      redirect_pc    = HANDLER_ADDR;
    end
    unique case (op_x)
      OP_GETQ: begin rd_we = 1'b1; rd_data = q_rd; end
      OP_MASK: begin rd_we = 1'b1; rd_data = XLEN'(mask_q); end
      OP_WAIT: begin rd_we = wait_done; rd_data = wait_done ? XLEN'(pend) : '0; end
      OP_RET:  begin redirect_valid = 1'b1; redirect_pc = q0; end
      default: ;
    endcase
  end

  // next state
  always_comb begin
    mask_d = (op_x == OP_MASK) ? rs1_val[NIRQ-1:0] : mask_q;
    if (take)                en_d = 1'b0;
    else if (op_x == OP_RET) en_d = 1'b1;
    else                     en_d = en_q;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      mask_q <= '1;
      en_q   <= 1'b1;
    end else begin
      mask_q <= mask_d;
      en_q   <= en_d;
    end
  end

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_ns)
    illegal |-> (!rd_we && !redirect_valid && !stall)); // R1
  AST_ENTRY_SAVES_PC: assert property (@(posedge clk) disable iff (!rst_ns)
    take |=> (q0 == $past(pc))); // R6
  AST_NO_NESTED_ENTRY: assert property (@(posedge clk) disable iff (!rst_ns)
    take |=> !take); // R7
  AST_RETURN_REENABLES: assert property (@(posedge clk) disable iff (!rst_ns)
    (op_x == OP_RET) |=> en_q); // R8
  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_ns)
    stall |-> (!rd_we && !redirect_valid)); // R9
endmodule

// File: tb/irq_unit_bench.sv
module irq_unit_bench;
  localparam logic [31:0] HADDR = 32'h0000_0010;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_valid;
  logic [31:0] instr, rs1_val, pc, irq_req;
  logic        rd_we, redirect_valid, stall, illegal;
  logic [4:0]  rd_addr;
  logic [31:0] rd_data, redirect_pc;

  int n_checks = 0;
  int n_fail   = 0;

  // bench model state
  logic [31:0] m_mask, m_pend, m_prev;
  logic [31:0] m_q [4];
  logic        m_en;

  always #10 clk = ~clk;

  irq_unit #(.XLEN(32), .NIRQ(32), .HANDLER_ADDR(HADDR)) u_irq_unit (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .rs1_val(rs1_val), .pc(pc), .irq_req(irq_req),
    .rd_we(rd_we), .rd_addr(rd_addr), .rd_data(rd_data),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .stall(stall), .illegal(illegal)
  );

  function automatic logic [31:0] mk(input logic [6:0] f7, input logic [4:0] rs1f,
                                     input logic [4:0] rdf, input logic [2:0] f3,
                                     input logic [4:0] rs2f);
    return {f7, rs2f, rs1f, f3, rdf, 7'b0001011};
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  // one cycle: drive, check against model, advance model
  task automatic step(input string tag, input logic v, input logic [31:0] ins,
                      input logic [31:0] rs1, input logic [31:0] pcv,
                      input logic [31:0] irq);
    int op; // 0 none 1 get 2 set 3 ret 4 mask 5 wait 6 illegal
    logic [31:0] unm, clrv, e_rdd, e_rpc;
    logic e_we, e_rv, e_st, e_il, tk;
    @(negedge clk);
    instr_valid = v; instr = ins; rs1_val = rs1; pc = pcv; irq_req = irq;
    #5;
    op = 0;
    if (v && ins[6:0] == 7'b0001011) begin
      if (ins[14:12] != 0 || ins[24:20] != 0 || ins[31:25] > 4) op = 6;
      else op = int'(ins[31:25]) + 1;
    end
    unm = m_pend & ~m_mask;
    tk  = m_en && (unm != 0) && (op != 5);
    if (tk) op = 0;
    e_we = 0; e_rdd = 0; e_rv = tk; e_rpc = HADDR; e_st = 0; e_il = (op == 6);
    clrv = tk ? unm : 32'h0;
    case (op)
      1: begin e_we = 1; e_rdd = m_q[ins[16:15]]; end
      3: begin e_rv = 1; e_rpc = m_q[0]; end
      4: begin e_we = 1; e_rdd = m_mask; end
      5: if (m_pend == 0) e_st = 1; else begin e_we = 1; e_rdd = m_pend; clrv = m_pend; end
      default: ;
    endcase
    chk(tag, "rd_we", {31'b0, rd_we}, {31'b0, e_we});
    if (e_we) begin
      chk(tag, "rd_addr", {27'b0, rd_addr}, {27'b0, ins[11:7]});
      chk(tag, "rd_data", rd_data, e_rdd);
    end
    chk(tag, "redirect_valid", {31'b0, redirect_valid}, {31'b0, e_rv});
    if (e_rv) chk(tag, "redirect_pc", redirect_pc, e_rpc);
    chk(tag, "stall", {31'b0, stall}, {31'b0, e_st});
    chk(tag, "illegal", {31'b0, illegal}, {31'b0, e_il});
    // advance
    if (tk) begin m_q[0] = pcv; m_q[1] = unm; m_en = 0; end
    if (op == 2) m_q[ins[8:7]] = rs1;
    if (op == 3) m_en = 1;
    if (op == 4) m_mask = rs1;
    m_pend = (m_pend & ~clrv) | (irq & ~m_prev);
    m_prev = irq;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] irqs, ins, rs1;
    void'($urandom(32'd1234));
    rst_n = 0; instr_valid = 0; instr = 0; rs1_val = 0; pc = 0; irq_req = 0;
    m_mask = '1; m_pend = 0; m_prev = 0; m_en = 1;
    for (int i = 0; i < 4; i++) m_q[i] = 'x;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R10: idle outputs, mask all ones, nothing pending
    step("R10", 0, 0, 0, 32'h100, 0);
    step("R10", 1, mk(7'd3, 5'd1, 5'd5, 0, 0), 32'hFFFF_FFFF, 32'h104, 0);
    step("R10", 1, mk(7'd4, 5'd0, 5'd6, 0, 0), 0, 32'h108, 0);
    // R3 / R2: fill and read shadow words
    for (int i = 0; i < 4; i++)
      step("R3", 1, mk(7'd1, 5'd2, 5'(i), 0, 0), 32'hA5A5_0000 + 32'(i), 32'h10C, 0);
    for (int i = 0; i < 4; i++)
      step("R2", 1, mk(7'd0, 5'(i), 5'd9 + 5'(i), 0, 0), 0, 32'h110, 0);
    // R4: two lines rise together under full mask, no entry
    step("R5", 1, 32'h0000_0013, 0, 32'h114, 32'h0000_0088);
    step("R4", 1, 32'h0000_0013, 0, 32'h118, 32'h0000_0088);
    step("R4", 1, 32'h0000_0013, 0, 32'h11C, 32'h0000_0088);
    // R4: open mask for bits 3,7,9 ; R6: entry with both bits
    step("R4", 1, mk(7'd3, 5'd3, 5'd7, 0, 0), ~32'h0000_0288, 32'h120, 32'h0000_0088);
    step("R6", 1, 32'h0000_0013, 0, 32'h124, 32'h0000_0088);
    step("R6", 1, mk(7'd0, 5'd1, 5'd10, 0, 0), 0, 32'h010, 32'h0000_0088);
    step("R6", 1, mk(7'd0, 5'd0, 5'd11, 0, 0), 0, 32'h014, 32'h0000_0088);
    // R7: new line inside handler stays pending, no nested entry
    step("R7", 1, 32'h0000_0013, 0, 32'h018, 32'h0000_0288);
    step("R7", 1, 32'h0000_0013, 0, 32'h01C, 32'h0000_0288);
    step("R7", 1, 32'h0000_0013, 0, 32'h020, 32'h0000_0288);
    // R8: return, then R7 deferred entry
    step("R8", 1, mk(7'd2, 5'd0, 5'd0, 0, 0), 0, 32'h024, 32'h0000_0288);
    step("R7", 1, 32'h0000_0013, 0, 32'h124, 32'h0000_0288);
    step("R7", 1, mk(7'd0, 5'd1, 5'd12, 0, 0), 0, 32'h010, 32'h0000_0288);
    step("R8", 1, mk(7'd2, 5'd0, 5'd0, 0, 0), 0, 32'h014, 0);
    // R9: wait completes on a masked-only request
    step("R9", 1, mk(7'd4, 5'd0, 5'd13, 0, 0), 0, 32'h128, 0);
    step("R9", 1, mk(7'd4, 5'd0, 5'd13, 0, 0), 0, 32'h128, 32'h0010_0000);
    step("R9", 1, mk(7'd4, 5'd0, 5'd13, 0, 0), 0, 32'h128, 32'h0010_0000);
    step("R9", 1, mk(7'd4, 5'd0, 5'd13, 0, 0), 0, 32'h128, 32'h0010_0000);
    // R1: illegal encodings and foreign opcode
    step("R1", 1, mk(7'd5, 5'd0, 5'd1, 0, 0), 32'h0, 32'h12C, 0);
    step("R1", 1, mk(7'd0, 5'd0, 5'd1, 3'd2, 0), 32'h0, 32'h130, 0);
    step("R1", 1, mk(7'd1, 5'd0, 5'd1, 0, 5'd4), 32'h0, 32'h134, 0);
    step("R1", 1, mk(7'd3, 5'd0, 5'd1, 0, 0) ^ 32'h0000_0020, 32'h0, 32'h138, 0);
    step("R1", 0, mk(7'd3, 5'd0, 5'd1, 0, 0), 32'h0, 32'h13C, 0);

    // random mix
    irqs = 0;
    for (int n = 0; n < 4000; n++) begin
      int sel;
      logic vv;
      sel = $urandom % 12;
      rs1 = $urandom;
      vv = 1;
      case (sel)
        0, 1:  ins = mk(7'd0, 5'($urandom), 5'($urandom), 0, 0);
        2:     ins = mk(7'd1, 5'($urandom), 5'($urandom), 0, 0);
        3:     ins = mk(7'd2, 5'd0, 5'd0, 0, 0);
        4:     begin ins = mk(7'd3, 5'($urandom), 5'($urandom), 0, 0);
                     rs1 = $urandom | $urandom | $urandom; end
        5:     ins = mk(7'd4, 5'd0, 5'($urandom), 0, 0);
        6:     ins = mk(7'(5 + $urandom % 123), 5'($urandom), 5'($urandom), 0, 0);
        7:     ins = mk(7'($urandom % 5), 5'($urandom), 5'($urandom),
                        3'(1 + $urandom % 7), 5'($urandom));
        8:     ins = {$urandom} & 32'hFFFF_FF80 | 32'h0000_0033;
        default: begin ins = $urandom; vv = 0; end
      endcase
      irqs = irqs ^ ($urandom & $urandom & $urandom & $urandom);
      step("RND", vv, ins, rs1, $urandom & 32'hFFFF_FFFC, irqs);
    end
    finish_run();
  end
endmodule